// File: doc/BRIEF.md
# Window Watchdog Timer

The block watches over software with a 7-bit down-counter that moves on a slow prescaled tick. Software must reload the counter inside a window. If it reloads while the counter is still above a programmed window value, that is too early. If it lets the counter fall through 0x40 to 0x3F, that is too late. Once the watchdog is activated, either mistake produces a one-clock reset pulse for the system.

One tick before the late limit, the counter reaches 0x40 and sets a sticky status flag. An early interrupt is raised from this flag when it is enabled. Three word registers sit behind a plain single-cycle write port with a combinational read:

- control at offset 0x00 holds the counter and the activation bit;
- configuration at offset 0x04 holds the window, the timer base and the interrupt enable;
- status at offset 0x08 holds the flag.

The base divider is a parameter. It defaults to 4096 and can be made short for simulation.

Top module: `window_watchdog`

## Requirements
- R1: The counter decrements once every PRE_DIV × 2^tb clock cycles, where tb is configuration bits 8:7 (00 → ×1, 01 → ×2, 10 → ×4, 11 → ×8).
- R2: While activated, a write to control (offset 0x00: bits 6:0 counter value, bit 7 activation) when the present counter is greater than the window (configuration bits 6:0) raises wdg_rst for one cycle after the write edge. A write when the counter is at or below the window raises no pulse.
- R3: While activated, the counter decrementing from 0x40 to 0x3F raises wdg_rst for exactly one cycle, and the counter then reads 0x3F.
- R4: The flag (status offset 0x08, bit 0) is set when the counter decrements to 0x40, whether or not the interrupt is enabled. early_irq is high only while both the flag and the enable (configuration bit 9) are 1.
- R5: Writing status with bit 0 at 0 clears the flag. Writing it with bit 0 at 1 leaves the flag unchanged.
- R6: Once the interrupt enable is set, later configuration writes cannot clear it. Only reset clears it.
- R7: Once the activation bit is set, later control writes cannot clear it. Only reset clears it.
- R8: After reset, control reads 0x7F, configuration reads 0x07F, status reads 0, and both outputs are low. Reserved bits and unmapped offsets read 0.
- R9: While not activated, the counter runs through 0x40 with no wdg_rst pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdg_rst | output | 1 | One-cycle system reset request |
| early_irq | output | 1 | Early warning interrupt |

## Verification
The assertions check four properties on every cycle:

- the activation bit and the interrupt enable never fall;
- the flag rises only from a 0x41 → 0x40 decrement;
- no reset pulse appears unless the block was already activated;
- every unreloaded 0x40 → 0x3F decrement while activated yields a pulse.

Only the bench's scenarios show the following:

- the tick period for each timer base;
- the early-refresh comparison over a sweep of window and counter values;
- the flag clear semantics;
- the reset and reserved-bit read values.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int PRE_DIV = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdg_rst,
  output logic        early_irq
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_CFG  = 4'h4;
  localparam logic [3:0] OFF_STAT = 4'h8;

  logic [PW-1:0] pre_q;
  logic [2:0]    sub_q;
  logic [6:0]    cnt_q, win_q;
  logic [1:0]    tb_q;
  logic          act_q, ewi_q, flag_q;
  logic          unused_bits;

  wire wr_ctrl = bus_wr && (bus_addr == OFF_CTRL);
  wire wr_cfg  = bus_wr && (bus_addr == OFF_CFG);
  wire wr_stat = bus_wr && (bus_addr == OFF_STAT);

  wire       base_tick = (pre_q == PW'(PRE_DIV - 1));
  wire [2:0] tb_mask   = {tb_q == 2'b11, tb_q[1], |tb_q};
  wire       tick      = base_tick && ((sub_q & tb_mask) == tb_mask);

  wire late_hit  = act_q && tick && !wr_ctrl && (cnt_q == 7'h40);
  wire early_hit = act_q && wr_ctrl && (cnt_q > win_q);
  wire flag_hit  = tick && !wr_ctrl && (cnt_q == 7'h41);

  assign unused_bits = ^bus_wdata[31:10];
  assign early_irq   = ewi_q & flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= base_tick ? '0 : pre_q + 1'b1;
      if (base_tick) sub_q <= sub_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= 7'h7F;
      act_q   <= 1'b0;
      win_q   <= 7'h7F;
      tb_q    <= 2'b00;
      ewi_q   <= 1'b0;
      flag_q  <= 1'b0;
      wdg_rst <= 1'b0;
    end else begin
      if (wr_ctrl)   cnt_q <= bus_wdata[6:0];
      else if (tick) cnt_q <= cnt_q - 7'd1;
      act_q <= act_q | (wr_ctrl & bus_wdata[7]);
      if (wr_cfg) begin
        win_q <= bus_wdata[6:0];
        tb_q  <= bus_wdata[8:7];
      end
      ewi_q <= ewi_q | (wr_cfg & bus_wdata[9]);
      if (flag_hit)                     flag_q <= 1'b1;
      else if (wr_stat && !bus_wdata[0]) flag_q <= 1'b0;
      wdg_rst <= late_hit | early_hit;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL: bus_rdata = {24'd0, act_q, cnt_q};
      OFF_CFG:  bus_rdata = {22'd0, ewi_q, tb_q, win_q};
      OFF_STAT: bus_rdata = {31'd0, flag_q};
      default:  bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/window_watchdog_chk.sv
module window_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [3:0] bus_addr,
  input logic       act,
  input logic       ewi,
  input logic       flag,
  input logic [6:0] cnt,
  input logic       wdg_rst
);
  wire wr_ctrl = bus_wr && (bus_addr == 4'h0);

  a_r6_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ewi |=> ewi);

  a_r7_activation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> act);

  a_r4_flag_from_0x41: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(cnt) == 7'h41));

  a_r9_no_pulse_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |-> $past(act));

  a_r3_late_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(act) && $fell(cnt[6]) && !$past(wr_ctrl)) |-> wdg_rst);
endmodule

bind window_watchdog window_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .act(act_q), .ewi(ewi_q), .flag(flag_q), .cnt(cnt_q), .wdg_rst(wdg_rst)
);

// File: tb/tb_window_watchdog.sv
`timescale 1ns/1ps
module tb_window_watchdog;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        wdg_rst, early_irq;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  window_watchdog #(.PRE_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdg_rst(wdg_rst), .early_irq(early_irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output logic rst_seen);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    rst_seen = wdg_rst;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(20ns * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not end");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        r;
    logic        bad_irq, bad_rst;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    check("R8 irq", {31'd0, early_irq}, 0);
    check("R8 rst", {31'd0, wdg_rst}, 0);
    rd(4'h0, d); check("R8 ctrl", d, 32'h7F);
    rd(4'h4, d); check("R8 cfg", d, 32'h07F);
    rd(4'h8, d); check("R8 status", d, 0);

    // R9 / R4: not activated, enable off: run through 0x40
    bad_irq = 0; bad_rst = 0;
    bus_addr = 4'h8;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (early_irq) bad_irq = 1;
      if (wdg_rst) bad_rst = 1;
    end
    check("R9 no pulse inactive", {31'd0, bad_rst}, 0);
    check("R4 irq masked", {31'd0, bad_irq}, 0);
    rd(4'h8, d); check("R4 flag set with enable off", d, 1);
    rd(4'h0, d); check("R9 counter passed 0x40", {31'd0, d[6] == 1'b0}, 1);

    // R5 clear semantics
    wr(4'h8, 32'h1, r); rd(4'h8, d); check("R5 write 1 keeps flag", d, 1);
    wr(4'h8, 32'h0, r); rd(4'h8, d); check("R5 write 0 clears flag", d, 0);

    // R8 reserved / unmapped, R6 sticky enable
    wr(4'h4, 32'hFFFF_FFFF, r); rd(4'h4, d); check("R8 cfg reserved zero", d, 32'h3FF);
    wr(4'h4, 32'h0, r);          rd(4'h4, d); check("R6 enable sticky", d, 32'h200);
    rd(4'hC, d); check("R8 unmapped reads 0", d, 0);

    // R7 sticky activation; counter 0x7F-ish above window 0 -> early pulse
    wr(4'h0, 32'hFFFF_FFFF, r); check("R2 first activation no pulse", {31'd0, r}, 0);
    rd(4'h0, d); check("R8 ctrl reserved zero", {24'd0, d[31:8]}, 0);
    wr(4'h0, 32'h50, r);
    check("R2 above window pulses", {31'd0, r}, 1);
    @(negedge clk); check("R3 pulse one cycle", {31'd0, wdg_rst}, 0);
    rd(4'h0, d); check("R7 activation sticky", {31'd0, d[7]}, 1);

    // R1 timer base sweep, R3 late pulse, R4 irq enabled
    for (int tb = 0; tb < 4; tb++) begin
      int t1, t2;
      logic [6:0] after;
      logic       second;
      wr(4'h4, 32'h200 | (tb << 7) | 32'h7F, r);
      wr(4'h0, 32'hC3, r);
      wr(4'h8, 32'h0, r);
      t1 = -1; t2 = -1; after = 0; second = 0;
      bus_addr = 4'h0;
      for (int i = 0; i < 3000 && t2 < 0; i++) begin
        @(negedge clk);
        #1;
        if (early_irq && t1 < 0) t1 = i;
        if (wdg_rst) begin t2 = i; after = bus_rdata[6:0]; end
      end
      @(negedge clk); second = wdg_rst;
      check($sformatf("R1 tick period tb=%0d", tb), t2 - t1, DIV << tb);
      check("R3 counter after late pulse", {25'd0, after}, 32'h3F);
      check("R3 late pulse one cycle", {31'd0, second}, 0);
      check("R4 irq with enable", {31'd0, early_irq}, 1);
    end

    // R2 window sweep: expected from the counter sampled in the write cycle
    begin
      logic [6:0] wins [4];
      wins[0] = 7'h7F; wins[1] = 7'h70; wins[2] = 7'h55; wins[3] = 7'h41;
      for (int w = 0; w < 4; w++) begin
        wr(4'h4, 32'h200 | {25'd0, wins[w]}, r);
        wr(4'h0, 32'h41, r);
        for (int v = 8'h7F; v >= 8'h41; v -= 3) begin
          logic [6:0] cur;
          @(negedge clk);
          bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = v;
          #1 cur = bus_rdata[6:0];
          @(negedge clk);
          bus_wr = 1'b0;
          check($sformatf("R2 win=%0h cur=%0h", wins[w], cur),
                {31'd0, wdg_rst}, {31'd0, cur > wins[w]});
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule